// File: doc/BRIEF.md
# Data Bus Pattern Tester

This block is a self-test engine for a wide memory data path. After a start pulse it writes a fixed series of bit patterns to a single memory word and reads each one back before it moves on. The series is chosen so that any two data lines that are adjacent on the board are driven to opposite levels at least once, whatever their routing. The complements of those patterns are also applied, so a line shorted to a neighbouring signal outside the bus is caught as well. The engine stops at the first word that does not read back unchanged and reports that pattern. It reports pass only after every pattern has matched.

The engine drives a simple synchronous memory port. The request channel is valid/ready. Once `mem_req_valid` is raised, the request (write enable, address, write data) stays unchanged until a cycle in which `mem_req_ready` is also high; that cycle is the transfer. The memory may hold `mem_req_ready` low for any number of cycles. Read data comes back on `mem_rdata` qualified by `mem_rvalid`, with any latency of one cycle or more. There is no back-pressure on the read-return path: the engine always accepts read data. Control and status (`start`, `busy`, `done`, `pass`, `fail_pattern`) are plain level or pulse signals.

Top module: `dbus_pattern_bist`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `busy`, `done`, `pass` and `mem_req_valid` are 0 and `fail_pattern` is all zeros.
- R2: The patterns come in a fixed order. With L = log2(DATA_W), pattern k for k < L has bit i equal to bit k of the index i. Pattern k for L <= k < 2L is the complement of pattern 2L-1-k. For 64 bits the order is AAAA…, CCCC…, F0F0…, FF00…, FFFF0000…, FFFFFFFF00000000, then their complements in reverse order, ending with 5555….
- R3: Every request carries address BASE_ADDR. Each write transfer is followed by a read transfer of the same word, and that read comes before the next write.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and keeps the same write enable and write data in the next cycle.
- R5: Read data is compared only when `mem_rvalid` is high while a read is outstanding. Any read latency of one cycle or more gives the same verdict. A `mem_rvalid` pulse while the engine is idle changes no output.
- R6: At the first mismatching read the test stops without issuing any further request. `pass` is 0 and `fail_pattern` holds the full pattern that failed.
- R7: If all 2L patterns read back unchanged, `pass` is 1 and `fail_pattern` is zero.
- R8: `done` is high for exactly one cycle, in the same cycle `busy` falls. `pass` and `fail_pattern` keep their values until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored. The run continues with no restart and no extra transfers.
- R10: An accepted start clears `pass` and `fail_pattern` to 0 in the cycle after it, and `busy` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test when idle |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse at test end |
| pass | output | 1 | All patterns matched (held) |
| fail_pattern | output | DATA_W | Pattern that failed, zero otherwise (held) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The assertions assume that the memory returns `mem_rvalid` only for a read it has accepted, at most once per read, and never in the same cycle as the transfer. They also assume `start` is a clean synchronous level. The bench memory model has a single outstanding-read counter, so it honours all of this. Its readiness and latency are randomised per run. The only stray `mem_rvalid` pulses it injects arrive while the engine is idle, which is the case R5 covers. Stuck-at and wired-AND bridging faults are applied to the stored word, so the point of first mismatch follows from the fault and the pattern list alone.

// File: rtl/dbpt_pkg.sv
package dbpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_WAIT  = 2'd3
  } dbpt_state_e;
endpackage

// File: rtl/dbpt_pattern_rom.sv
module dbpt_pattern_rom #(
  parameter int DATA_W = 64,
  parameter int LOG_W  = 6,
  parameter int NPAT   = 12,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] pat
);
  // base_w[k] alternates groups of 2**k ones and zeros, low group zero
  logic [DATA_W-1:0] base_w [LOG_W];

  for (genvar k = 0; k < LOG_W; k++) begin : g_base
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign base_w[k][b] = ((b >> k) % 2) == 1;
    end
  end

  // first half ascending, second half complements in mirrored order
  always_comb begin
    pat = '0;
    for (int k = 0; k < LOG_W; k++) begin
      if (idx == IDX_W'(k))            pat = base_w[k];
      if (idx == IDX_W'(NPAT - 1 - k)) pat = ~base_w[k];
    end
  end
endmodule

// File: rtl/dbpt_cmp.sv
module dbpt_cmp #(
  parameter int DATA_W = 64
) (
  input  logic              armed,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] exp_pat,
  output logic              hit,
  output logic              miss
);
  logic take;
  logic same;

  assign take = armed && rvalid;
  assign same = (rdata == exp_pat);
  assign hit  = take && same;
  assign miss = take && !same;
endmodule

// File: rtl/dbpt_seq.sv
module dbpt_seq
  import dbpt_pkg::*;
#(
  parameter int NPAT  = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_ready,
  input  logic             cmp_hit,
  input  logic             cmp_miss,
  output dbpt_state_e      state,
  output logic [IDX_W-1:0] idx,
  output logic             fin_ev,
  output logic             fin_pass,
  output logic             accept_start
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPAT - 1);

  dbpt_state_e state_n;
  logic [IDX_W-1:0] idx_n;

  assign accept_start = (state == ST_IDLE) && start;
  assign fin_ev   = (state == ST_WAIT) && (cmp_miss || (cmp_hit && idx == LAST));
  assign fin_pass = cmp_hit;

  always_comb begin
    state_n = state;
    idx_n   = idx;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_WRITE;
          idx_n   = '0;
        end
      end
      ST_WRITE: if (req_ready) state_n = ST_READ;
      ST_READ:  if (req_ready) state_n = ST_WAIT;
      ST_WAIT: begin
        if (cmp_miss) begin
          state_n = ST_IDLE;
        end else if (cmp_hit) begin
          if (idx == LAST) begin
            state_n = ST_IDLE;
          end else begin
            state_n = ST_WRITE;
            idx_n   = idx + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_n;
      idx   <= idx_n;
    end
  end
endmodule

// File: rtl/dbus_pattern_bist.sv
module dbus_pattern_bist
  import dbpt_pkg::*;
#(
  parameter int               DATA_W    = 64,
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [DATA_W-1:0] fail_pattern,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam int NPAT  = 2 * LOG_W;
  localparam int IDX_W = $clog2(NPAT);

  dbpt_state_e      state;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] cur_pat;
  logic cmp_hit, cmp_miss, fin_ev, fin_pass, accept_start;

  dbpt_pattern_rom #(
    .DATA_W(DATA_W), .LOG_W(LOG_W), .NPAT(NPAT), .IDX_W(IDX_W)
  ) u_rom (
    .idx (idx),
    .pat (cur_pat)
  );

  dbpt_seq #(
    .NPAT(NPAT), .IDX_W(IDX_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .req_ready    (mem_req_ready),
    .cmp_hit      (cmp_hit),
    .cmp_miss     (cmp_miss),
    .state        (state),
    .idx          (idx),
    .fin_ev       (fin_ev),
    .fin_pass     (fin_pass),
    .accept_start (accept_start)
  );

  dbpt_cmp #(
    .DATA_W(DATA_W)
  ) u_cmp (
    .armed   (state == ST_WAIT),
    .rvalid  (mem_rvalid),
    .rdata   (mem_rdata),
    .exp_pat (cur_pat),
    .hit     (cmp_hit),
    .miss    (cmp_miss)
  );

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_WRITE) || (state == ST_READ);
  assign mem_we        = (state == ST_WRITE);
  assign mem_addr      = BASE_ADDR;
  assign mem_wdata     = mem_req_valid ? cur_pat : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= 1'b0;
      pass         <= 1'b0;
      fail_pattern <= '0;
    end else begin
      done <= fin_ev;
      if (accept_start) begin
        pass         <= 1'b0;
        fail_pattern <= '0;
      end else if (fin_ev) begin
        pass         <= fin_pass;
        fail_pattern <= fin_pass ? '0 : cur_pat;
      end
    end
  end
endmodule

// File: rtl/dbpt_assert.sv
module dbpt_assert #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [DATA_W-1:0] fail_pattern,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R3
  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_we) |=> (mem_req_valid && !mem_we)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_we) && $stable(mem_wdata))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> ($stable(pass) && $stable(fail_pattern))); // R8
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (fail_pattern == '0)); // R7
endmodule

bind dbus_pattern_bist dbpt_assert #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_dbpt_assert (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .pass          (pass),
  .fail_pattern  (fail_pattern),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_wdata     (mem_wdata)
);

// File: tb/dbus_pattern_bist_bench.sv
`timescale 1ns/1ps
module dbus_pattern_bist_bench;
  localparam int DW = 64;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h002A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass;
  logic [DW-1:0] fail_pattern;
  logic mem_req_valid, mem_req_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_rvalid;

  always #10 clk = ~clk;

  dbus_pattern_bist #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) u_dbus_pattern_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .fail_pattern(fail_pattern), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] pats [12] = '{
    64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
    64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000,
    64'h00000000FFFFFFFF, 64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF,
    64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333, 64'h5555555555555555};

  // memory model configuration
  int lat = 1, rdy_pct = 100;
  logic [DW-1:0] sa_mask = '0, sa_val = '0;
  bit br_en = 0;
  int br_a = 0, br_b = 1;
  logic spur = 1'b0;

  function automatic logic [DW-1:0] fault(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    logic v;
    r = (w & ~sa_mask) | (sa_val & sa_mask);
    if (br_en) begin
      v = r[br_a] & r[br_b];
      r[br_a] = v;
      r[br_b] = v;
    end
    return r;
  endfunction

  logic [DW-1:0] mem_word = '0, pend = '0, rd_q = '0;
  logic rv_q = 1'b0;
  int cnt = 0;
  int wr_cnt = 0, rd_cnt = 0, addr_err = 0, seq_err = 0, hold_err = 0;
  bit last_we = 0;
  logic [DW-1:0] wlog [16];
  logic pv = 0, pr = 0, pwe = 0;
  logic [DW-1:0] pwd = '0;

  assign mem_rvalid = rv_q | spur;
  assign mem_rdata  = spur ? 64'hDEAD_BEEF_0123_4567 : rd_q;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      if (mem_addr != BASE) addr_err++;
      if (mem_we) begin
        if (last_we) seq_err++;
        mem_word <= fault(mem_wdata);
        if (wr_cnt < 16) wlog[wr_cnt] = mem_wdata;
        wr_cnt++;
        last_we = 1;
      end else begin
        if (!last_we) seq_err++;
        rd_cnt++;
        last_we = 0;
        pend <= mem_word;
        cnt <= lat;
      end
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
    rv_q <= (cnt == 1);
    rd_q <= pend;
    if (rst_n && pv && !pr)
      if (!mem_req_valid || mem_we != pwe || mem_wdata != pwd) hold_err++;
    pv <= mem_req_valid; pr <= mem_req_ready; pwe <= mem_we; pwd <= mem_wdata;
  end

  always @(negedge clk) mem_req_ready = ($urandom_range(99) < rdy_pct);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_test(input bit poke);
    int exp_idx, cyc;
    bit seen;
    logic [DW-1:0] exp_fail;
    exp_idx = 12;
    for (int k = 11; k >= 0; k--)
      if (fault(pats[k]) != pats[k]) exp_idx = k;
    exp_fail = (exp_idx == 12) ? '0 : pats[exp_idx];
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; addr_err = 0; seq_err = 0; hold_err = 0; last_we = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !pass && fail_pattern == '0, "R10 start clears", {fail_pattern[DW-3:0], busy, pass}, 64'h2);
    seen = 0;
    for (cyc = 0; cyc < 2000 && !seen; cyc++) begin
      @(negedge clk);
      if (done) seen = 1;
      else start = (poke && cyc == 3);
    end
    start = 1'b0;
    chk(seen, "R8 done seen", 64'(seen), 64'd1);
    if (seen) begin
      chk(!busy, "R8 busy low with done", 64'(busy), 64'd0);
      chk(pass == (exp_idx == 12), "R7 pass", 64'(pass), 64'(exp_idx == 12));
      chk(fail_pattern == exp_fail, "R6 fail pattern", fail_pattern, exp_fail);
      chk(wr_cnt == ((exp_idx == 12) ? 12 : exp_idx + 1), "R9 R6 write count",
          64'(wr_cnt), 64'((exp_idx == 12) ? 12 : exp_idx + 1));
      chk(rd_cnt == wr_cnt, "R3 reads match writes", 64'(rd_cnt), 64'(wr_cnt));
      chk(addr_err == 0 && seq_err == 0, "R3 address and order", 64'(addr_err + seq_err), 64'd0);
      chk(hold_err == 0, "R4 request hold", 64'(hold_err), 64'd0);
      for (int k = 0; k < wr_cnt && k < 12; k++)
        chk(wlog[k] == pats[k], "R2 pattern order", wlog[k], pats[k]);
      @(negedge clk);
      chk(!done, "R8 done single cycle", 64'(done), 64'd0);
      spur = 1'b1;
      @(negedge clk);
      spur = 1'b0;
      repeat (3) @(negedge clk);
      chk(!done && !busy, "R5 idle rvalid ignored", 64'({done, busy}), 64'd0);
      chk(pass == (exp_idx == 12) && fail_pattern == exp_fail, "R8 R5 results held", fail_pattern, exp_fail);
    end
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !mem_req_valid && fail_pattern == '0, "R1 in reset",
        64'({busy, done, pass, mem_req_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pass && !mem_req_valid && fail_pattern == '0, "R1 after reset",
        64'({busy, done, pass, mem_req_valid}), 64'd0);
    // directed: clean memory, full ready, latency 1
    lat = 1; rdy_pct = 100; run_test(1'b0);
    // directed: clean memory, long latency, back-pressure, start poked while busy (R9)
    lat = 4; rdy_pct = 40; run_test(1'b1);
    // directed: bit 0 stuck at 1 fails the first pattern (R6)
    sa_mask = 64'h1; sa_val = 64'h1; run_test(1'b1);
    // directed: bit 63 stuck at 1 only shows on a complement pattern
    sa_mask = 64'h8000_0000_0000_0000; sa_val = sa_mask; lat = 2; run_test(1'b0);
    // directed: wired-AND bridge of bits 0 and 32 first shows at the sixth pattern
    sa_mask = '0; sa_val = '0; br_en = 1; br_a = 0; br_b = 32; run_test(1'b1);
    br_en = 0;
    // random runs
    for (int r = 0; r < 8; r++) begin
      int mode, a;
      lat = $urandom_range(4, 1);
      rdy_pct = $urandom_range(100, 30);
      mode = $urandom_range(2);
      sa_mask = '0; sa_val = '0; br_en = 0;
      if (mode == 1) begin
        a = $urandom_range(DW - 1);
        sa_mask[a] = 1'b1;
        sa_val[a] = 1'($urandom_range(1));
      end else if (mode == 2) begin
        br_en = 1;
        br_a = $urandom_range(DW - 1);
        br_b = (br_a + 1 + $urandom_range(DW - 2)) % DW;
      end
      run_test(1'($urandom_range(1)));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule